// File: doc/BRIEF.md
# Seven-to-One Four-Lane Display Serializer

This block turns a 28-bit parallel pixel word into four serial data lanes plus a forwarded clock lane. Each pixel period has seven bit slots. It runs entirely on the bit-rate clock, which is seven times the pixel rate. An internal slot counter marks the pixel boundaries. The upstream source presents a word together with a one-cycle capture strobe. The word is held in a capture register and moves into the four lane shift registers only at the boundary between slot 6 and slot 0. One word is therefore serialized per period, with no gap and no repeated bit between words.

The bits of each lane are gathered from the word in a fixed, non-sequential order that a matching receiver expects. The clock lane is high for the first four slots of each period and low for the last three, so its rising edge lines up with the first bit of each word. An active-low shutdown input clears all state and holds every output low. After shutdown is released, a lock-wait counter delays the link-valid flag; this stands in for the settling time of an external clock multiplier. A parameter selects a 21-bit variant in which the fourth lane is not built and stays low.

Top module: `disp_serializer_7to1`

## Requirements
- R1: While `shdn_n` is low, at the next clock edge all lanes, `clk_lane` and `link_valid` go to 0. Words strobed during shutdown are discarded, so the first period after release carries an all-zero word.
- R2: `pix_word` is captured at every bit-clock edge where `pix_mark` is high. If several captures happen within one period, the last one before the boundary is the word that is serialized.
- R3: A captured word reaches the lanes only at the slot-6 to slot-0 boundary, and lane bits never change mid-word. A word captured at the edge that ends slot 6 misses that boundary and goes out one period later.
- R4: Lane 0 sends, in slots 0 to 6, word bits 7, 6, 4, 3, 2, 1, 0.
- R5: Lane 1 sends, in slots 0 to 6, word bits 18, 15, 14, 13, 12, 9, 8.
- R6: Lane 2 sends, in slots 0 to 6, word bits 26, 25, 24, 22, 21, 20, 19.
- R7: With `FULL_WIDTH`=1, lane 3 sends, in slots 0 to 6, word bits 23, 17, 16, 11, 10, 5, 27.
- R8: `clk_lane` is 1 in slots 0 to 3 and 0 in slots 4 to 6 of every period. The first slot of the first period after release is slot 0.
- R9: `link_valid` is 0 for the first `LOCK_CYCLES`-1 edges after release and 1 from edge `LOCK_CYCLES` on. Once high, it stays high until the next shutdown.
- R10: With `FULL_WIDTH`=0, lane 3 is constantly 0, and lanes 0 to 2 behave exactly as in the 28-bit build.
- R11: Words captured in consecutive periods come out in consecutive periods, with no idle or repeated slot between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, seven edges per pixel period |
| shdn_n | input | 1 | Active-low synchronous shutdown and clear |
| pix_mark | input | 1 | Capture strobe for `pix_word` |
| pix_word | input | 28 | Parallel pixel word |
| lane_q | output | 4 | Serial data lanes, one bit per slot |
| clk_lane | output | 1 | Forwarded pixel clock, 4 slots high and 3 slots low |
| link_valid | output | 1 | High once the lock wait after release has elapsed |

## Verification
The clock-lane properties look up to five cycles into the past. They therefore assume that every shutdown is held low for at least four bit clocks, so that the history they read is either low or from a full period. The bench always holds shutdown for five or more cycles. It changes `shdn_n`, `pix_mark` and `pix_word` only on falling clock edges. The bench places capture strobes in chosen slots, including the slot that ends a period, so that the boundary rule is checked on both sides.

// File: rtl/disp_ser_pkg.sv
// Shared constants, types and the fixed lane bit-gather map for the serializer.
// Assumes a 7-slot period and four lanes; the map is part of the link format.
package disp_ser_pkg;

    localparam int NUM_LANES  = 4;
    localparam int SLOT_COUNT = 7;
    localparam int WORD_BITS  = NUM_LANES * SLOT_COUNT;
    localparam int IDX_W      = $clog2(WORD_BITS);

    typedef logic [SLOT_COUNT-1:0] slice_t;
    typedef logic [WORD_BITS-1:0]  word_t;

    // Word bit index sent by a lane in a slot (slot 0 goes out first).
    function automatic int src_bit(input int lane, input int slot);
        int key;
        key = lane * 8 + slot;
        case (key)
            0:  return 7;   1:  return 6;   2:  return 4;   3:  return 3;
            4:  return 2;   5:  return 1;   6:  return 0;
            8:  return 18;  9:  return 15;  10: return 14;  11: return 13;
            12: return 12;  13: return 9;   14: return 8;
            16: return 26;  17: return 25;  18: return 24;  19: return 22;
            20: return 21;  21: return 20;  22: return 19;
            24: return 23;  25: return 17;  26: return 16;  27: return 11;
            28: return 10;  29: return 5;   30: return 27;
            default: return 0;
        endcase
    endfunction

    // Collect a lane's seven bits; slot 0 lands in the MSB so it shifts out first.
    function automatic slice_t gather(input word_t w, input int lane);
        slice_t s;
        logic [IDX_W-1:0] idx;
        s = '0;
        for (int p = 0; p < SLOT_COUNT; p++) begin
            idx = IDX_W'(src_bit(lane, p));
            s[SLOT_COUNT-1-p] = w[idx];
        end
        return s;
    endfunction

endpackage

// File: rtl/disp_ser_slot_timer.sv
// Slot counter and forwarded-clock generator.
// Counts bit slots 0..SLOTS-1; flags the last slot as the word boundary.
// Shutdown parks the counter on the last slot, so the release edge is a boundary.
// Assumes HIGH_SLOTS < SLOTS.
module disp_ser_slot_timer #(
    parameter int SLOTS      = 7,
    parameter int HIGH_SLOTS = (SLOTS + 1) / 2
) (
    input  logic clk,
    input  logic shdn_n,
    output logic boundary_o,
    output logic clk_lane_o
);
    localparam int            SW   = $clog2(SLOTS);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
    localparam logic [SW-1:0] HIGH = SW'(HIGH_SLOTS);

    logic [SW-1:0] slot_q;
    logic [SW-1:0] slot_d;
    logic          clk_q;

    // Next slot with wrap at the end of the period.
    always_comb slot_d = (slot_q == LAST) ? '0 : slot_q + 1'b1;

    // Advance the slot and register the clock-lane level of the coming slot.
    always_ff @(posedge clk) begin
        if (!shdn_n) begin
            slot_q <= LAST;
            clk_q  <= 1'b0;
        end else begin
            slot_q <= slot_d;
            clk_q  <= (slot_d < HIGH);
        end
    end

    assign boundary_o = (slot_q == LAST);
    assign clk_lane_o = clk_q;

endmodule

// File: rtl/disp_ser_lock_wait.sv
// Lock-wait timer: counts bit clocks after shutdown release and raises
// locked_o after WAIT_CYCLES edges. Holds until the next shutdown.
// Assumes WAIT_CYCLES >= 1.
module disp_ser_lock_wait #(
    parameter int unsigned WAIT_CYCLES = 4096
) (
    input  logic clk,
    input  logic shdn_n,
    output logic locked_o
);
    localparam int            CW   = $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] DONE = CW'(WAIT_CYCLES);

    logic [CW-1:0] cnt_q;

    // Saturating count of edges since release.
    always_ff @(posedge clk) begin
        if (!shdn_n)
            cnt_q <= '0;
        else if (cnt_q != DONE)
            cnt_q <= cnt_q + 1'b1;
    end

    assign locked_o = (cnt_q == DONE);

endmodule

// File: rtl/disp_ser_capture.sv
// Holding register for the parallel word; loads on every strobed edge.
// Assumes the strobe is synchronous to the bit clock.
module disp_ser_capture #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             shdn_n,
    input  logic             take_i,
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] word_o
);
    logic [WIDTH-1:0] hold_q;

    // Capture the incoming word when strobed; clear on shutdown.
    always_ff @(posedge clk) begin
        if (!shdn_n)
            hold_q <= '0;
        else if (take_i)
            hold_q <= word_i;
    end

    assign word_o = hold_q;

endmodule

// File: rtl/disp_ser_lane_shift.sv
// One lane: parallel-load, MSB-first shift register.
// When ACTIVE is 0 no register is built and the lane output is tied low.
// Assumes load_i pulses once per period, in the last slot.
module disp_ser_lane_shift #(
    parameter int SLOTS  = 7,
    parameter bit ACTIVE = 1'b1
) (
    input  logic             clk,
    input  logic             shdn_n,
    input  logic             load_i,
    input  logic [SLOTS-1:0] par_i,
    output logic             ser_o
);
    if (ACTIVE) begin : g_on
        logic [SLOTS-1:0] sh_q;

        // Load a fresh slice at the boundary, otherwise shift towards the MSB.
        always_ff @(posedge clk) begin
            if (!shdn_n)
                sh_q <= '0;
            else if (load_i)
                sh_q <= par_i;
            else
                sh_q <= {sh_q[SLOTS-2:0], 1'b0};
        end

        assign ser_o = sh_q[SLOTS-1];
    end else begin : g_off
        assign ser_o = 1'b0;
    end

endmodule

// File: rtl/disp_serializer_7to1.sv
// Seven-to-one serializer top: capture register, slot timer, lock wait and
// four lane shifters fed by the fixed bit-gather map.
// Runs wholly on the bit-rate clock; shdn_n is a synchronous active-low clear.
module disp_serializer_7to1
    import disp_ser_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 4096,
    parameter bit          FULL_WIDTH  = 1'b1
) (
    input  logic                 clk,
    input  logic                 shdn_n,
    input  logic                 pix_mark,
    input  logic [WORD_BITS-1:0] pix_word,
    output logic [NUM_LANES-1:0] lane_q,
    output logic                 clk_lane,
    output logic                 link_valid
);
    logic  boundary;
    word_t cap_word;

    disp_ser_slot_timer #(
        .SLOTS(SLOT_COUNT)
    ) u_timer (
        .clk       (clk),
        .shdn_n    (shdn_n),
        .boundary_o(boundary),
        .clk_lane_o(clk_lane)
    );

    disp_ser_lock_wait #(
        .WAIT_CYCLES(LOCK_CYCLES)
    ) u_lock (
        .clk     (clk),
        .shdn_n  (shdn_n),
        .locked_o(link_valid)
    );

    disp_ser_capture #(
        .WIDTH(WORD_BITS)
    ) u_cap (
        .clk   (clk),
        .shdn_n(shdn_n),
        .take_i(pix_mark),
        .word_i(pix_word),
        .word_o(cap_word)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam bit ACT = (g != NUM_LANES - 1) || FULL_WIDTH;
        slice_t par;

        assign par = gather(cap_word, g);

        disp_ser_lane_shift #(
            .SLOTS (SLOT_COUNT),
            .ACTIVE(ACT)
        ) u_shift (
            .clk   (clk),
            .shdn_n(shdn_n),
            .load_i(boundary),
            .par_i (par),
            .ser_o (lane_q[g])
        );
    end

endmodule

// File: rtl/disp_ser_checks.sv
// Protocol checks on the serializer's ports, bound to every instance.
// Assumes each shutdown lasts at least four bit clocks.
module disp_ser_checks (
    input logic       clk,
    input logic       shdn_n,
    input logic [3:0] lane_q,
    input logic       clk_lane,
    input logic       link_valid
);
    // R1: shutdown clears every output by the next edge.
    a_r1_shutdown_clears: assert property (@(posedge clk)
        !shdn_n |=> (lane_q == 4'b0 && !clk_lane && !link_valid));

    // R8: a falling clock lane ends a run of exactly four high slots.
    a_r8_high_four: assert property (@(posedge clk) disable iff (!shdn_n)
        ($fell(clk_lane) && $past(shdn_n)) |->
            ($past(clk_lane, 2) && $past(clk_lane, 3) && $past(clk_lane, 4)
             && !$past(clk_lane, 5)));

    // R8: a rising clock lane follows at least three low slots.
    a_r8_low_three: assert property (@(posedge clk) disable iff (!shdn_n)
        $rose(clk_lane) |-> (!$past(clk_lane, 2) && !$past(clk_lane, 3)));

    // R9: link_valid stays high until shutdown.
    a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!shdn_n)
        link_valid |=> link_valid);

endmodule

bind disp_serializer_7to1 disp_ser_checks u_checks (
    .clk       (clk),
    .shdn_n    (shdn_n),
    .lane_q    (lane_q),
    .clk_lane  (clk_lane),
    .link_valid(link_valid)
);

// File: tb/tb_disp_serializer_7to1.sv
// Directed bench: a 28-bit build (dut) and a 21-bit build share the stimulus.
module tb_disp_serializer_7to1;

    localparam int LOCK = 20;

    logic        clk = 1'b0;
    logic        shdn_n = 1'b0;
    logic        pix_mark = 1'b0;
    logic [27:0] pix_word = '0;
    logic [3:0]  lane_q, lane_q21;
    logic        clk_lane, clk_lane21, link_valid, link_valid21;

    int checks = 0;
    int errors = 0;
    int n_rel = 0;
    logic [27:0] cap_model = '0;
    logic [27:0] cur_model = '0;

    always #10 clk = ~clk;

    // Edges since shutdown release, counted by the bench.
    always @(posedge clk) begin
        if (!shdn_n) n_rel <= 0;
        else         n_rel <= n_rel + 1;
    end

    disp_serializer_7to1 #(.LOCK_CYCLES(LOCK), .FULL_WIDTH(1'b1)) dut (
        .clk(clk), .shdn_n(shdn_n), .pix_mark(pix_mark), .pix_word(pix_word),
        .lane_q(lane_q), .clk_lane(clk_lane), .link_valid(link_valid));

    disp_serializer_7to1 #(.LOCK_CYCLES(LOCK), .FULL_WIDTH(1'b0)) dut21 (
        .clk(clk), .shdn_n(shdn_n), .pix_mark(pix_mark), .pix_word(pix_word),
        .lane_q(lane_q21), .clk_lane(clk_lane21), .link_valid(link_valid21));

    // Word bit sent by a lane in a slot, from the requirement list.
    function automatic int tb_bit(input int lane, input int slot);
        int t0 [7] = '{7, 6, 4, 3, 2, 1, 0};
        int t1 [7] = '{18, 15, 14, 13, 12, 9, 8};
        int t2 [7] = '{26, 25, 24, 22, 21, 20, 19};
        int t3 [7] = '{23, 17, 16, 11, 10, 5, 27};
        case (lane)
            0: return t0[slot];
            1: return t1[slot];
            2: return t2[slot];
            default: return t3[slot];
        endcase
    endfunction

    function automatic logic [6:0] exp_slice(input logic [27:0] w, input int lane);
        logic [6:0] s;
        for (int p = 0; p < 7; p++) s[6-p] = w[tb_bit(lane, p)];
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    // One period, starting at the slot-0 falling edge; up to two strobes.
    task automatic run_period(input string tag, input int sa, input logic [27:0] wa,
                              input int sb, input logic [27:0] wb);
        logic [6:0]  got [4];
        logic [6:0]  got21 [4];
        logic [6:0]  gclk;
        logic [27:0] cur;
        string lt [4] = '{"R4", "R5", "R6", "R7"};
        cur = cur_model;
        for (int i = 0; i < 7; i++) begin
            for (int l = 0; l < 4; l++) begin
                got[l][6-i]   = lane_q[l];
                got21[l][6-i] = lane_q21[l];
            end
            gclk[6-i] = clk_lane;
            if (n_rel == LOCK - 1) begin
                check("R9 valid before lock", {31'b0, link_valid}, 32'd0);
                check("R9 valid21 before lock", {31'b0, link_valid21}, 32'd0);
            end
            if (n_rel == LOCK) begin
                check("R9 valid at lock", {31'b0, link_valid}, 32'd1);
                check("R9 valid21 at lock", {31'b0, link_valid21}, 32'd1);
            end
            pix_mark = 1'b0;
            if (i == sa) begin pix_mark = 1'b1; pix_word = wa; end
            if (i == sb) begin pix_mark = 1'b1; pix_word = wb; end
            @(posedge clk);
            if (i == 6) cur_model = cap_model;
            if (i == sa) cap_model = wa;
            if (i == sb) cap_model = wb;
            @(negedge clk);
        end
        pix_mark = 1'b0;
        for (int l = 0; l < 4; l++)
            check({tag, " ", lt[l]}, {25'b0, got[l]}, {25'b0, exp_slice(cur, l)});
        for (int l = 0; l < 3; l++)
            check({tag, " R10 low lanes"}, {25'b0, got21[l]}, {25'b0, exp_slice(cur, l)});
        check({tag, " R10 lane3 low"}, {25'b0, got21[3]}, 32'd0);
        check({tag, " R8 clock lane"}, {25'b0, gclk}, 32'b1111000);
    endtask

    task automatic t_shutdown_hold();
        @(negedge clk);
        shdn_n = 1'b0; pix_mark = 1'b1; pix_word = 28'hFFF_FFFF;
        repeat (5) @(negedge clk);
        check("R1 lanes in shutdown", {28'b0, lane_q}, 32'd0);
        check("R1 clock lane in shutdown", {31'b0, clk_lane}, 32'd0);
        check("R1 valid in shutdown", {30'b0, link_valid, link_valid21}, 32'd0);
        pix_mark = 1'b0;
    endtask

    task automatic t_release();
        shdn_n = 1'b1;
        @(negedge clk);
        cap_model = '0;
        cur_model = '0;
        run_period("R1 first word zero", -1, '0, -1, '0);
    endtask

    task automatic t_single_bits();
        for (int b = 0; b < 28; b++)
            run_period("map", 0, 28'd1 << b, -1, '0);
        run_period("map tail", -1, '0, -1, '0);
    endtask

    task automatic t_back_to_back();
        run_period("R11 a", 0, 28'hFFF_FFFF, -1, '0);
        run_period("R11 b", 0, 28'h5A5_A5A5, -1, '0);
        run_period("R11 c", 0, 28'hA5A_5A5A, -1, '0);
        run_period("R11 d", 0, 28'h123_4567, -1, '0);
        run_period("R11 e", -1, '0, -1, '0);
    endtask

    task automatic t_last_capture_wins();
        run_period("R2 two strobes", 1, 28'h0F0_F0F0, 5, 28'hC3C_3C3C);
        run_period("R2 result", -1, '0, -1, '0);
    endtask

    task automatic t_boundary_strobe();
        run_period("R3 prime", 0, 28'h00F_FFF0, -1, '0);
        run_period("R3 slot6 strobe", 6, 28'hBEE_F123, -1, '0);
        run_period("R3 late word", -1, '0, -1, '0);
        run_period("R3 hold", -1, '0, -1, '0);
    endtask

    task automatic t_shutdown_mid();
        check("R9 valid sticky", {31'b0, link_valid}, 32'd1);
        pix_mark = 1'b1; pix_word = 28'h7FF_FFFF;
        shdn_n = 1'b0;
        @(negedge clk);
        check("R1 lanes after mid shutdown", {28'b0, lane_q}, 32'd0);
        check("R1 clock after mid shutdown", {31'b0, clk_lane}, 32'd0);
        check("R1 valid after mid shutdown", {31'b0, link_valid}, 32'd0);
        repeat (4) @(negedge clk);
        pix_mark = 1'b0;
        t_release();
    endtask

    initial begin
        t_shutdown_hold();
        t_release();
        t_single_bits();
        t_back_to_back();
        t_last_capture_wins();
        t_boundary_strobe();
        t_shutdown_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule